// File: doc/BRIEF.md
# Byte Transmit Path with Elastic Buffering and Flow Control

This block carries bytes from a host toward a line transmitter. Bytes enter through a valid/data write port into a small front FIFO. The front FIFO feeds a large elastic buffer at up to one byte per clock. The line side drains the elastic buffer through a ready/valid read port, oldest byte first. When the front FIFO is full, an incoming byte is discarded without any recovery. Each discarded byte advances a saturating counter, which the host can clear.

Flow control toward the host uses two thresholds on the elastic buffer's occupancy, set far apart. In hardware mode an active-low clear-to-send output goes high once the buffer fills to the upper mark. It returns low only after the buffer drains below the lower mark. Between the two marks it keeps its previous level. In software mode the clear-to-send output stays low. The block instead puts a single stop character (0x13) on a one-cycle side channel when the buffer crosses the upper mark, and a single resume character (0x11) when it falls below the lower mark.

Top module: `etb_tx_path`

## Requirements
- R1: While reset is high and on the first cycle after it, `cts_n` is 0, `rd_valid` is 0, `ctl_valid` is 0 and `ovf_count` is 0.
- R2: Every accepted byte appears on `rd_data` exactly once, in the order in which it was written.
- R3: In hardware mode (`sw_flow_en`=0), `cts_n` is 1 in the cycle after elastic occupancy is at least HI_MARK (796 by default).
- R4: In hardware mode, `cts_n` is 0 in the cycle after elastic occupancy is below LO_MARK (128 by default).
- R5: While occupancy stays from LO_MARK to HI_MARK-1, `cts_n` keeps the level it had.
- R6: The elastic buffer holds at most ELASTIC_DEPTH (1024) bytes and the front FIFO at most FRONT_DEPTH (14). A byte written while the front FIFO holds FRONT_DEPTH bytes is discarded and never reaches `rd_data`.
- R7: `ovf_count` increments by one for each discarded byte, saturates at its maximum, and returns to 0 in the cycle after `ovf_clear` is high. A clear takes priority over a drop in the same cycle.
- R8: In software mode (`sw_flow_en`=1), `cts_n` stays 0. Crossing the upper mark produces exactly one `ctl_valid` pulse with `ctl_data`=0x13.
- R9: In software mode, falling below the lower mark produces exactly one `ctl_valid` pulse with `ctl_data`=0x11.
- R10: The front FIFO moves at most one byte per clock into the elastic buffer, and only when the elastic buffer is not full. A byte written at one clock edge reaches `rd_valid` after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host byte strobe |
| wr_data | input | 8 | Host byte |
| sw_flow_en | input | 1 | 1 selects stop/resume characters, 0 selects the clear-to-send pin |
| ovf_clear | input | 1 | Clears the discard counter |
| rd_ready | input | 1 | Line side accepts a byte |
| rd_valid | output | 1 | Elastic buffer has a byte |
| rd_data | output | 8 | Oldest buffered byte |
| cts_n | output | 1 | Clear-to-send, active low |
| ctl_valid | output | 1 | One-cycle strobe for a flow-control character |
| ctl_data | output | 8 | Flow-control character, 0x13 stop or 0x11 resume |
| ovf_count | output | OVF_W | Saturating count of discarded bytes |

## Verification
A corrupted pointer or occupancy count appears at `rd_data` as an out-of-order or repeated byte at the next read. It also shifts the cycle in which `cts_n` flips, away from the exact byte count at which the bench expects it. A stuck hysteresis flag shows as `cts_n` following a single threshold, which the hold phases between the marks expose within three cycles. A wrong discard decision shows either as an extra byte in the drained stream or as an `ovf_count` value that differs from the number of writes made against a full front FIFO.

// File: rtl/etb_pkg.sv
package etb_pkg;

    localparam logic [7:0] CHAR_STOP   = 8'h13;
    localparam logic [7:0] CHAR_RESUME = 8'h11;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } side_byte_t;

    function automatic byte_t flow_char(input logic stop);
        return stop ? CHAR_STOP : CHAR_RESUME;
    endfunction

endpackage

// File: rtl/etb_ring.sv
module etb_ring #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  etb_pkg::byte_t   in_data,
    output logic             in_ready,
    output logic             out_valid,
    output etb_pkg::byte_t   out_data,
    input  logic             out_ready,
    output logic [CNT_W-1:0] occupancy
);

    etb_pkg::byte_t   mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push;
    logic             pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign in_ready  = (count != CNT_W'(DEPTH));
    assign out_valid = (count != '0);
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_ptr];
    assign occupancy = count;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds the configured depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R10: occupancy moves by at most one byte per clock
    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1) ||
        (count == $past(count) - 1'b1));

    // R6: a full ring refuses the next byte
    assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) && !out_ready |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/etb_ovf_counter.sv
module etb_ovf_counter #(
    parameter int OVF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drop,
    input  logic             clear,
    output logic [OVF_W-1:0] count
);

    logic at_max;
    assign at_max = &count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (drop && !at_max) begin
            count <= count + 1'b1;
        end
    end

    // R7: each discarded byte adds exactly one
    assert_drop_counts_R7: assert property (@(posedge clk) disable iff (rst)
        drop && !clear && !at_max |=> count == $past(count) + 1'b1);

    // R7: clear wins and zeroes the counter
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0);

endmodule

// File: rtl/etb_flow_ctrl.sv
module etb_flow_ctrl #(
    parameter int CNT_W   = 11,
    parameter int HI_MARK = 796,
    parameter int LO_MARK = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_mode,
    input  logic [CNT_W-1:0]    occ,
    output logic                cts_n,
    output etb_pkg::side_byte_t ctl
);

    logic stop_q;
    logic stop_d;

    always_comb begin
        if (occ >= CNT_W'(HI_MARK)) begin
            stop_d = 1'b1;
        end else if (occ < CNT_W'(LO_MARK)) begin
            stop_d = 1'b0;
        end else begin
            stop_d = stop_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
            ctl    <= '0;
        end else begin
            stop_q     <= stop_d;
            ctl.valid  <= sw_mode && (stop_d != stop_q);
            ctl.data   <= etb_pkg::flow_char(stop_d);
        end
    end

    assign cts_n = stop_q && !sw_mode;

    // R3: upper mark deasserts clear-to-send in hardware mode
    assert_cts_high_R3: assert property (@(posedge clk) disable iff (rst)
        !sw_mode && (occ >= CNT_W'(HI_MARK)) |=> cts_n || sw_mode);

    // R4: below the lower mark clear-to-send is active again
    assert_cts_low_R4: assert property (@(posedge clk) disable iff (rst)
        occ < CNT_W'(LO_MARK) |=> !cts_n);

    // R5: between the marks the pin holds its level
    assert_cts_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !sw_mode && (occ >= CNT_W'(LO_MARK)) && (occ < CNT_W'(HI_MARK))
        |=> (cts_n == $past(cts_n)) || sw_mode);

    // R8: software mode never drives the pin inactive
    assert_sw_pin_R8: assert property (@(posedge clk) disable iff (rst)
        sw_mode |-> !cts_n);

    // R9: side channel carries only the two flow characters, one cycle each
    assert_side_char_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.valid |-> (ctl.data == etb_pkg::CHAR_STOP) ||
                      (ctl.data == etb_pkg::CHAR_RESUME));

endmodule

// File: rtl/etb_tx_path.sv
module etb_tx_path #(
    parameter int FRONT_DEPTH   = 14,
    parameter int ELASTIC_DEPTH = 1024,
    parameter int HI_MARK       = 796,
    parameter int LO_MARK       = 128,
    parameter int OVF_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             sw_flow_en,
    input  logic             ovf_clear,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             cts_n,
    output logic             ctl_valid,
    output logic [7:0]       ctl_data,
    output logic [OVF_W-1:0] ovf_count
);

    localparam int FRONT_CNT_W = $clog2(FRONT_DEPTH + 1);
    localparam int ELAST_CNT_W = $clog2(ELASTIC_DEPTH + 1);

    logic                   front_in_ready;
    logic                   front_out_valid;
    etb_pkg::byte_t         front_out_data;
    logic                   elast_in_ready;
    logic [FRONT_CNT_W-1:0] front_occ;
    logic [ELAST_CNT_W-1:0] elast_occ;
    logic                   drop;
    etb_pkg::side_byte_t    ctl;

    assign drop = wr_valid && !front_in_ready;

    etb_ring #(.DEPTH(FRONT_DEPTH)) u_front (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (wr_valid),
        .in_data   (wr_data),
        .in_ready  (front_in_ready),
        .out_valid (front_out_valid),
        .out_data  (front_out_data),
        .out_ready (elast_in_ready),
        .occupancy (front_occ)
    );

    etb_ring #(.DEPTH(ELASTIC_DEPTH)) u_elastic (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (front_out_valid),
        .in_data   (front_out_data),
        .in_ready  (elast_in_ready),
        .out_valid (rd_valid),
        .out_data  (rd_data),
        .out_ready (rd_ready),
        .occupancy (elast_occ)
    );

    etb_ovf_counter #(.OVF_W(OVF_W)) u_ovf (
        .clk   (clk),
        .rst   (rst),
        .drop  (drop),
        .clear (ovf_clear),
        .count (ovf_count)
    );

    etb_flow_ctrl #(
        .CNT_W   (ELAST_CNT_W),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_flow (
        .clk     (clk),
        .rst     (rst),
        .sw_mode (sw_flow_en),
        .occ     (elast_occ),
        .cts_n   (cts_n),
        .ctl     (ctl)
    );

    assign ctl_valid = ctl.valid;
    assign ctl_data  = ctl.data;

    // R6: a discard only happens against a full front FIFO
    assert_drop_only_full_R6: assert property (@(posedge clk) disable iff (rst)
        drop |-> front_occ == FRONT_CNT_W'(FRONT_DEPTH));

    // R10: the front FIFO holds its bytes while the elastic buffer is full
    assert_no_move_full_R10: assert property (@(posedge clk) disable iff (rst)
        (elast_occ == ELAST_CNT_W'(ELASTIC_DEPTH)) && !wr_valid
        |=> front_occ == $past(front_occ));

endmodule

// File: tb/etb_tx_path_bench.sv
module etb_tx_path_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int   push_n;
        int   pop_n;
        logic exp_cts;
        int   req;
    } phase_t;

    // occupancy after each phase: 795,796,496,128,127,727,796,0
    localparam phase_t PHASES [8] = '{
        '{795, 0,   1'b0, 3},
        '{1,   0,   1'b1, 3},
        '{0,   300, 1'b1, 5},
        '{0,   368, 1'b1, 5},
        '{0,   1,   1'b0, 4},
        '{600, 0,   1'b0, 5},
        '{69,  0,   1'b1, 3},
        '{0,   796, 1'b0, 4}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic        sw_flow_en;
    logic        ovf_clear;
    logic        rd_ready;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        cts_n;
    logic        ctl_valid;
    logic [7:0]  ctl_data;
    logic [15:0] ovf_count;

    int checks = 0;
    int errors = 0;
    int stop_seen = 0;
    int resume_seen = 0;
    logic [7:0] wseq = 8'd0;
    logic [7:0] rseq = 8'd0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    etb_tx_path u_etb_tx_path (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .sw_flow_en(sw_flow_en), .ovf_clear(ovf_clear), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .cts_n(cts_n),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ovf_count(ovf_count)
    );

    always @(negedge clk) begin
        if (!rst && ctl_valid) begin
            if (ctl_data == 8'h13) stop_seen++;
            else if (ctl_data == 8'h11) resume_seen++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = wseq;
            @(negedge clk);
            wseq++;
        end
        wr_valid = 1'b0;
    endtask

    // R2: every read byte follows the write order
    task automatic pop_n(input int n);
        int got = 0;
        int guard = 0;
        rd_ready = 1'b1;
        while (got < n && guard < 5000) begin
            if (rd_valid) begin
                check("R2 order", rd_data, rseq);
                got++;
                rseq++;
            end
            guard++;
            @(negedge clk);
        end
        rd_ready = 1'b0;
        check("R2 pop count", got, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_data = '0; sw_flow_en = 1'b0;
        ovf_clear = 1'b0; rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cts_n", cts_n, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 ctl_valid", ctl_valid, 0);
        check("R1 ovf_count", ovf_count, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cts_n after release", cts_n, 0);

        // R10: two-edge latency from write to read port
        push_n(1);
        check("R10 not yet visible", rd_valid, 0);
        @(negedge clk);
        check("R10 visible", rd_valid, 1);
        check("R10 data", rd_data, wseq - 8'd1);
        pop_n(1);

        // hysteresis table: R3 R4 R5
        foreach (PHASES[p]) begin
            if (PHASES[p].push_n > 0) begin
                push_n(PHASES[p].push_n);
                repeat (4) @(negedge clk);
            end
            if (PHASES[p].pop_n > 0) begin
                pop_n(PHASES[p].pop_n);
                repeat (3) @(negedge clk);
            end
            check($sformatf("R%0d phase %0d cts_n", PHASES[p].req, p), cts_n, PHASES[p].exp_cts);
        end
        check("R8 no side chars in hardware mode", stop_seen + resume_seen, 0);

        // software mode: R8 R9
        sw_flow_en = 1'b1;
        push_n(796);
        repeat (4) @(negedge clk);
        check("R8 cts_n held low", cts_n, 0);
        check("R8 single stop char", stop_seen, 1);
        check("R9 no resume yet", resume_seen, 0);
        pop_n(669);
        repeat (3) @(negedge clk);
        check("R9 single resume char", resume_seen, 1);
        check("R8 stop count unchanged", stop_seen, 1);
        pop_n(127);
        sw_flow_en = 1'b0;
        repeat (2) @(negedge clk);

        // overflow: R6 R7
        push_n(1024);
        repeat (4) @(negedge clk);
        check("R3 full buffer cts_n", cts_n, 1);
        push_n(14);
        repeat (2) @(negedge clk);
        check("R7 no drops yet", ovf_count, 0);
        for (int i = 0; i < 5; i++) begin
            wr_valid = 1'b1;
            wr_data  = wseq + 8'd100;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        @(negedge clk);
        check("R7 five drops counted", ovf_count, 5);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        check("R7 cleared", ovf_count, 0);
        pop_n(1038);
        repeat (3) @(negedge clk);
        check("R6 dropped bytes absent", rd_valid, 0);
        check("R4 drained cts_n", cts_n, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule